// File: doc/BRIEF.md
# SMI Event Control and Arbiter

This block combines several system events into a single active-low system-management interrupt line to the processor. An 8-bit control word holds a master enable, an end-of-service handshake bit, one enable per event source, the start bit of a software countdown timer, and a write-only bit that fires an SCI pulse. Each enabled source latches a sticky status bit. The interrupt line is requested while any status bit is set and the master enable is on.

The arbiter spaces out interrupts with a software handshake. Hardware clears the end-of-service bit in the same clock edge that pulls the line low. The line then stays low until software sets that bit again. The one exception is the first interrupt after reset, which may be raised with the bit clear. Before each assertion the line is held high for a fixed gap of PCI clocks. A write of one to the sleep-enable bit can be intercepted: when interception is on, the write raises an event and the sleep transition is withheld. When interception is off, the transition is permitted.

Top module: `smi_ctl_arbiter`

## Requirements
- R1: Control bit 0 is the master enable. While it is 0 the interrupt line never falls, although status bits still latch. A reset clears the whole control word to 0.
- R2: Control bit 1 is the end-of-service bit. Hardware clears it on the edge where `smi_n` falls. `smi_n` then stays low until software writes the bit to 1. On the clock after that write, `smi_n` returns high.
- R3: After reset, the first assertion of `smi_n` needs no end-of-service bit. Every later assertion waits until that bit is 1.
- R4: Before each fall of `smi_n` the line is high for GAP_CLKS (4) consecutive clocks. A status bit still pending when the end-of-service bit is set causes a new assertion after that gap.
- R5: Status bits are sticky. Bit 0 is APM command, bit 1 is sleep request, bit 2 is legacy USB, bit 3 is global release and bit 4 is timer. A bit is set on the edge after its event occurs while its source enable is 1. A bit is cleared by writing 1 to its position through `sts_clr_wr`/`sts_clr_mask`, and other bits are unaffected.
- R6: Control bit 4 enables sleep interception. When it is 1, `slp_req` sets status bit 1 and `slp_permit` stays 0. When it is 0, `slp_permit` follows `slp_req` in the same cycle and no status is set.
- R7: Control bit 5 enables the APM source, bit 3 enables the legacy USB source and bit 2 enables the global-release source. An event whose enable is 0 sets no status.
- R8: Control bit 6 runs the software timer. Timer status (bit 4) sets TMR_FAST (16) clocks after the enabling write when `tmr_rate` is 0, and TMR_SLOW (64) clocks after it when `tmr_rate` is 1. Clearing bit 6 before expiry restarts the count.
- R9: Control bit 7 is write-only and always reads 0. Writing it as 1 gives `sci_pulse` high for exactly the one cycle after the write. Writing it as 0 gives no pulse.
- R10: `reg_rdata` returns control bits 6..0 as last written, except for the hardware clear of bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, also the timer and gap timebase |
| rst_n | input | 1 | Active-low PCI reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data (bit 7 reads 0) |
| sts_clr_wr | input | 1 | Status write-one-to-clear strobe |
| sts_clr_mask | input | 5 | Status bits to clear |
| sts | output | 5 | Sticky per-source status |
| ev_apm | input | 1 | Write to the APM command port |
| slp_req | input | 1 | Write of 1 to the sleep-enable bit |
| ev_usb | input | 1 | Legacy USB request |
| ev_gbl_rls | input | 1 | Write of 1 to the global-release bit |
| tmr_rate | input | 1 | Timer timeout select (0 fast, 1 slow) |
| smi_n | output | 1 | Active-low interrupt line to the processor |
| sci_pulse | output | 1 | One-cycle SCI pulse |
| slp_permit | output | 1 | Sleep transition may proceed |

## Verification
The assertions check on every cycle the properties that hold at each fall of `smi_n`: the line was high for the full gap, the master enable was on, and the end-of-service bit reads back clear. They also check that the line stays low while that bit is clear, that bit 7 never reads 1, that every SCI pulse follows a write of bit 7, and that a sleep permit never appears while interception is on. Other behaviour can only be shown by the bench's scenarios. This covers the first-after-reset exception and the refusal of a later assertion without the handshake. It also covers re-assertion for a status still pending, and selective clearing of status. The exact timer expiry cycle at both rates, and the restart of the timer when it is disabled early, are also shown only by the bench.

// File: rtl/smi_pkg.sv
package smi_pkg;

   localparam int unsigned CTRL_W = 8;
   localparam int unsigned NUM_SRC = 5;

   localparam int unsigned C_MASTER = 0;
   localparam int unsigned C_EOS    = 1;
   localparam int unsigned C_GRLS   = 2;
   localparam int unsigned C_USB    = 3;
   localparam int unsigned C_SLP    = 4;
   localparam int unsigned C_APM    = 5;
   localparam int unsigned C_TMR    = 6;
   localparam int unsigned C_SCI    = 7;

   localparam int unsigned S_APM  = 0;
   localparam int unsigned S_SLP  = 1;
   localparam int unsigned S_USB  = 2;
   localparam int unsigned S_GRLS = 3;
   localparam int unsigned S_TMR  = 4;

   typedef enum logic [1:0] {
      ARB_IDLE   = 2'd0,
      ARB_GAP    = 2'd1,
      ARB_ACTIVE = 2'd2
   } arb_state_e;

endpackage

// File: rtl/smi_ctrl_regs.sv
module smi_ctrl_regs
   import smi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   input  logic              eos_hw_clr,
   output logic [CTRL_W-2:0] ctrl_q,
   output logic              sci_req
);

   // Bit 7 is never stored; only the request it makes leaves this module.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (reg_wr) begin
            ctrl_q <= reg_wdata[CTRL_W-2:0];
         end
         if (eos_hw_clr) begin
            ctrl_q[C_EOS] <= 1'b0;
         end
      end
   end

   assign sci_req = reg_wr & reg_wdata[C_SCI];

endmodule

// File: rtl/smi_src_status.sv
module smi_src_status #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] src_en,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] sts_q
);

   logic [N-1:0] clr_vec;
   assign clr_vec = clr_wr ? clr_mask : '0;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sts_q[i] <= 1'b0;
         end else if (ev[i] && src_en[i]) begin
            sts_q[i] <= 1'b1;
         end else if (clr_vec[i]) begin
            sts_q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/smi_sw_timer.sv
module smi_sw_timer #(
   parameter int unsigned TMR_FAST = 16,
   parameter int unsigned TMR_SLOW = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic rate_sel,
   output logic expire
);

   localparam int unsigned TMR_MAX = (TMR_SLOW > TMR_FAST) ? TMR_SLOW : TMR_FAST;
   localparam int unsigned TW = $clog2(TMR_MAX + 1);

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] lim;

   assign lim    = rate_sel ? TW'(TMR_SLOW - 1) : TW'(TMR_FAST - 1);
   assign expire = run && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || expire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/smi_arbiter.sv
module smi_arbiter
   import smi_pkg::*;
#(
   parameter int unsigned GAP_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic eos,
   output logic eos_hw_clr,
   output logic smi_n
);

   localparam int unsigned GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

   arb_state_e    st_q, st_d;
   logic [GW-1:0] gap_q, gap_d;
   logic          first_done_q;

   always_comb begin
      st_d       = st_q;
      gap_d      = gap_q;
      eos_hw_clr = 1'b0;
      case (st_q)
         ARB_IDLE: begin
            if (req && (eos || !first_done_q)) begin
               st_d  = ARB_GAP;
               gap_d = '0;
            end
         end
         ARB_GAP: begin
            if (!req) begin
               st_d = ARB_IDLE;
            end else if (gap_q == GW'(GAP_CLKS - 1)) begin
               st_d       = ARB_ACTIVE;
               eos_hw_clr = 1'b1;
            end else begin
               gap_d = gap_q + 1'b1;
            end
         end
         ARB_ACTIVE: begin
            if (eos) begin
               st_d = ARB_IDLE;
            end
         end
         default: st_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ARB_IDLE;
         gap_q        <= '0;
         first_done_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         gap_q <= gap_d;
         if (eos_hw_clr) begin
            first_done_q <= 1'b1;
         end
      end
   end

   assign smi_n = (st_q != ARB_ACTIVE);

endmodule

// File: rtl/smi_ctl_arbiter.sv
module smi_ctl_arbiter
   import smi_pkg::*;
#(
   parameter int unsigned GAP_CLKS = 4,
   parameter int unsigned TMR_FAST = 16,
   parameter int unsigned TMR_SLOW = 64,
   parameter bit          SCI_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   input  logic               sts_clr_wr,
   input  logic [4:0]         sts_clr_mask,
   output logic [4:0]         sts,
   input  logic               ev_apm,
   input  logic               slp_req,
   input  logic               ev_usb,
   input  logic               ev_gbl_rls,
   input  logic               tmr_rate,
   output logic               smi_n,
   output logic               sci_pulse,
   output logic               slp_permit
);

   if (GAP_CLKS < 1) begin : g_bad_gap
      $error("GAP_CLKS must be at least 1");
   end
   if (TMR_FAST < 2) begin : g_bad_fast
      $error("TMR_FAST must be at least 2");
   end
   if (TMR_SLOW < TMR_FAST) begin : g_bad_slow
      $error("TMR_SLOW must not be below TMR_FAST");
   end

   logic [CTRL_W-2:0]  ctrl;
   logic               eos_hw_clr;
   logic               sci_req;
   logic               tmr_expire;
   logic [NUM_SRC-1:0] ev_vec;
   logic [NUM_SRC-1:0] en_vec;
   logic               smi_req;

   smi_ctrl_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .eos_hw_clr (eos_hw_clr),
      .ctrl_q     (ctrl),
      .sci_req    (sci_req)
   );

   smi_sw_timer #(
      .TMR_FAST (TMR_FAST),
      .TMR_SLOW (TMR_SLOW)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl[C_TMR]),
      .rate_sel (tmr_rate),
      .expire   (tmr_expire)
   );

   always_comb begin
      ev_vec         = '0;
      en_vec         = '0;
      ev_vec[S_APM]  = ev_apm;
      ev_vec[S_SLP]  = slp_req;
      ev_vec[S_USB]  = ev_usb;
      ev_vec[S_GRLS] = ev_gbl_rls;
      ev_vec[S_TMR]  = tmr_expire;
      en_vec[S_APM]  = ctrl[C_APM];
      en_vec[S_SLP]  = ctrl[C_SLP];
      en_vec[S_USB]  = ctrl[C_USB];
      en_vec[S_GRLS] = ctrl[C_GRLS];
      en_vec[S_TMR]  = ctrl[C_TMR];
   end

   smi_src_status #(
      .N (NUM_SRC)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev_vec),
      .src_en   (en_vec),
      .clr_wr   (sts_clr_wr),
      .clr_mask (sts_clr_mask),
      .sts_q    (sts)
   );

   assign smi_req = ctrl[C_MASTER] && (|sts);

   smi_arbiter #(
      .GAP_CLKS (GAP_CLKS)
   ) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (smi_req),
      .eos        (ctrl[C_EOS]),
      .eos_hw_clr (eos_hw_clr),
      .smi_n      (smi_n)
   );

   if (SCI_REG) begin : g_sci_reg
      logic sci_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sci_q <= 1'b0;
         end else begin
            sci_q <= sci_req;
         end
      end
      assign sci_pulse = sci_q;
   end else begin : g_sci_comb
      assign sci_pulse = sci_req;
   end

   assign slp_permit = slp_req & ~ctrl[C_SLP];
   assign reg_rdata  = {1'b0, ctrl};

endmodule

// File: rtl/smi_ctl_arbiter_chk.sv
module smi_ctl_arbiter_chk #(
   parameter int unsigned GAP_CLKS = 4,
   parameter bit          SCI_REG  = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic smi_n,
   input logic rd_master,
   input logic rd_eos,
   input logic rd_slp,
   input logic rd_b7,
   input logic reg_wr,
   input logic wd7,
   input logic sci_pulse,
   input logic slp_permit,
   input logic slp_req
);

   localparam int unsigned HW = $clog2(GAP_CLKS + 1) + 1;

   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (!smi_n) begin
         hi_cnt <= '0;
      end else if (hi_cnt < HW'(GAP_CLKS)) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

   p_gap_before_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smi_n) |-> ($past(hi_cnt) >= HW'(GAP_CLKS)));

   p_master_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smi_n) |-> $past(rd_master));

   p_eos_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smi_n) |-> !rd_eos);

   p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_n && !rd_eos) |=> !smi_n);

   p_bit7_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_b7);

   p_no_permit_intercept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      slp_permit |-> (slp_req && !rd_slp));

   if (SCI_REG) begin : g_sci_chk
      p_sci_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
         sci_pulse |-> $past(reg_wr && wd7));
   end

endmodule

bind smi_ctl_arbiter smi_ctl_arbiter_chk #(
   .GAP_CLKS (GAP_CLKS),
   .SCI_REG  (SCI_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smi_n      (smi_n),
   .rd_master  (reg_rdata[0]),
   .rd_eos     (reg_rdata[1]),
   .rd_slp     (reg_rdata[4]),
   .rd_b7      (reg_rdata[7]),
   .reg_wr     (reg_wr),
   .wd7        (reg_wdata[7]),
   .sci_pulse  (sci_pulse),
   .slp_permit (slp_permit),
   .slp_req    (slp_req)
);

// File: tb/smi_ctl_arbiter_test.sv
`timescale 1ns/1ps
module smi_ctl_arbiter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sts_clr_wr = 1'b0;
   logic [4:0] sts_clr_mask = '0;
   logic [4:0] sts;
   logic       ev_apm = 1'b0;
   logic       slp_req = 1'b0;
   logic       ev_usb = 1'b0;
   logic       ev_gbl_rls = 1'b0;
   logic       tmr_rate = 1'b0;
   logic       smi_n;
   logic       sci_pulse;
   logic       slp_permit;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #2 clk = ~clk;

   smi_ctl_arbiter uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .sts_clr_wr   (sts_clr_wr),
      .sts_clr_mask (sts_clr_mask),
      .sts          (sts),
      .ev_apm       (ev_apm),
      .slp_req      (slp_req),
      .ev_usb       (ev_usb),
      .ev_gbl_rls   (ev_gbl_rls),
      .tmr_rate     (tmr_rate),
      .smi_n        (smi_n),
      .sci_pulse    (sci_pulse),
      .slp_permit   (slp_permit)
   );

   // {sci expected, write data, read-back expected}
   localparam logic [16:0] VEC [0:6] = '{
      {1'b1, 8'h80, 8'h00},
      {1'b0, 8'h01, 8'h01},
      {1'b0, 8'h7F, 8'h7F},
      {1'b1, 8'hFE, 8'h7E},
      {1'b0, 8'h55, 8'h55},
      {1'b1, 8'hAA, 8'h2A},
      {1'b0, 8'h00, 8'h00}
   };

   task automatic tick();
      @(posedge clk);
      #1;
      cycles++;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(logic [7:0] d);
      reg_wr    = 1'b1;
      reg_wdata = d;
      tick();
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic clr_sts(logic [4:0] m);
      sts_clr_wr   = 1'b1;
      sts_clr_mask = m;
      tick();
      sts_clr_wr   = 1'b0;
      sts_clr_mask = '0;
   endtask

   task automatic pulse_ev(logic a, logic u, logic g);
      ev_apm     = a;
      ev_usb     = u;
      ev_gbl_rls = g;
      tick();
      ev_apm     = 1'b0;
      ev_usb     = 1'b0;
      ev_gbl_rls = 1'b0;
   endtask

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
      end
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      tick();
      tick();
      // R1 reset state
      check("R1 reset ctrl", reg_rdata, 8'h00);
      check("R1 reset smi_n", smi_n, 1'b1);
      check("R5 reset sts", sts, 5'h00);
      check("R9 reset sci", sci_pulse, 1'b0);
      rst_n = 1'b1;
      tick();

      // R10 / R9 vector walk
      for (int i = 0; i < 7; i++) begin
         wr_ctrl(VEC[i][15:8]);
         check("R10 readback", reg_rdata, VEC[i][7:0]);
         check("R9 sci after write", sci_pulse, VEC[i][16]);
         tick();
         check("R9 sci one cycle", sci_pulse, 1'b0);
      end

      // R3 first assertion without end-of-service, R4 gap
      wr_ctrl(8'h21);
      pulse_ev(1'b1, 1'b0, 1'b0);
      check("R5 apm status", sts, 5'h01);
      check("R4 high before gap", smi_n, 1'b1);
      for (int i = 0; i < 4; i++) begin
         tick();
         check("R4 gap high", smi_n, 1'b1);
      end
      tick();
      check("R3 first smi low", smi_n, 1'b0);
      check("R2 eos clear", reg_rdata[1], 1'b0);
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R2 held low", smi_n, 1'b0);
      end

      // R2 release by end-of-service write
      clr_sts(5'h01);
      check("R5 w1c", sts, 5'h00);
      wr_ctrl(8'h23);
      check("R2 still low on write", smi_n, 1'b0);
      tick();
      check("R2 release high", smi_n, 1'b1);
      tick();
      check("R2 eos kept", reg_rdata[1], 1'b1);

      // R3 later assertion needs end-of-service
      wr_ctrl(8'h21);
      pulse_ev(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) begin
         tick();
         check("R3 blocked without eos", smi_n, 1'b1);
      end
      wr_ctrl(8'h23);
      check("R4 high on eos write", smi_n, 1'b1);
      for (int i = 0; i < 4; i++) begin
         tick();
         check("R4 gap high 2", smi_n, 1'b1);
      end
      tick();
      check("R3 second smi low", smi_n, 1'b0);
      check("R2 hw clear eos", reg_rdata[1], 1'b0);

      // R4 re-assertion while status pending
      wr_ctrl(8'h23);
      check("R4 low on write", smi_n, 1'b0);
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R4 re-gap high", smi_n, 1'b1);
      end
      tick();
      check("R4 re-asserted", smi_n, 1'b0);
      clr_sts(5'h01);
      wr_ctrl(8'h23);
      tick();
      check("R2 final release", smi_n, 1'b1);

      // R1 master enable off
      wr_ctrl(8'h22);
      pulse_ev(1'b1, 1'b0, 1'b0);
      check("R1 status latches", sts, 5'h01);
      for (int i = 0; i < 8; i++) begin
         tick();
         check("R1 no smi", smi_n, 1'b1);
      end
      clr_sts(5'h1F);

      // R7 source enables
      wr_ctrl(8'h02);
      pulse_ev(1'b1, 1'b1, 1'b1);
      check("R7 disabled sources", sts, 5'h00);
      wr_ctrl(8'h0E);
      pulse_ev(1'b1, 1'b1, 1'b1);
      check("R7 usb and grls only", sts, 5'h0C);
      clr_sts(5'h04);
      check("R5 selective clear", sts, 5'h08);
      clr_sts(5'h1F);
      wr_ctrl(8'h22);
      pulse_ev(1'b1, 1'b0, 1'b0);
      check("R7 apm enabled", sts, 5'h01);
      clr_sts(5'h1F);

      // R6 sleep interception
      wr_ctrl(8'h02);
      slp_req = 1'b1;
      #1;
      check("R6 permit when off", slp_permit, 1'b1);
      tick();
      slp_req = 1'b0;
      check("R6 no status when off", sts, 5'h00);
      wr_ctrl(8'h12);
      slp_req = 1'b1;
      #1;
      check("R6 permit blocked", slp_permit, 1'b0);
      tick();
      slp_req = 1'b0;
      check("R6 status set", sts, 5'h02);
      clr_sts(5'h1F);

      // R8 timer fast
      tmr_rate = 1'b0;
      wr_ctrl(8'h42);
      for (int i = 0; i < 15; i++) tick();
      check("R8 fast not yet", sts[4], 1'b0);
      tick();
      check("R8 fast expiry", sts[4], 1'b1);
      wr_ctrl(8'h02);
      clr_sts(5'h1F);

      // R8 restart when disabled early
      wr_ctrl(8'h42);
      for (int i = 0; i < 10; i++) tick();
      wr_ctrl(8'h02);
      wr_ctrl(8'h42);
      for (int i = 0; i < 15; i++) tick();
      check("R8 restart no early", sts[4], 1'b0);
      tick();
      check("R8 restart expiry", sts[4], 1'b1);
      wr_ctrl(8'h02);
      clr_sts(5'h1F);

      // R8 timer slow
      tmr_rate = 1'b1;
      wr_ctrl(8'h42);
      for (int i = 0; i < 63; i++) tick();
      check("R8 slow not yet", sts[4], 1'b0);
      tick();
      check("R8 slow expiry", sts[4], 1'b1);
      wr_ctrl(8'h02);
      clr_sts(5'h1F);

      // R1 reset clears control word
      wr_ctrl(8'h23);
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      check("R1 reset clears ctrl", reg_rdata, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule